// File: doc/BRIEF.md
# Slave-Serial FPGA Configuration Sequencer

This block is the master side of a slave-serial configuration link to a downstream FPGA. A start pulse launches a fixed sequence. The block turns on the target's supply switch and waits for it to settle. It then pulses the active-low program line for a fixed interval and polls the init-ready input until the target can accept data. Next it takes exactly `byte_len` bytes from a valid/ready byte stream and shifts each one out MSB first on a data pin, with a configuration clock whose phases are timed by a programmable divider. After the last byte it keeps pulsing the configuration clock until the target raises done.

Both waiting phases have a hard limit: the init poll and the trailing free-running clock. Either limit expiring ends the sequence with an error. An error flagged by the byte source also ends it. Status (success, or failure with the activity indicator left on) is held until the next start. The byte source only sees `src_ready` while the block is waiting for the next byte, so it can be a plain FIFO or an unpacker.

Top module: `cfgseq_top`

## Requirements
- R1: After reset: `prog_n`=1, `cfg_clk`=0, `cfg_data`=0, `pwr_en`=0, `src_ready`=0, `busy`=0, `act_ind`=0, `success`=0, `fail`=0.
- R2: A start pulse accepted while idle raises `pwr_en` and `busy`. `prog_n` then stays high for exactly PWR_CYC system cycles before it falls. `pwr_en` stays high for the rest of the sequence.
- R3: `prog_n` is held low for exactly PROG_CYC system cycles, then released high once per sequence.
- R4: After the release, `init_ready` is polled once per system cycle for at most POLL_MAX polls. A high level seen at any of those polls, including the last one, lets the sequence go on. If none is seen, the block stops with `fail`=1 and `act_ind`=1, `busy`=0, and issues no configuration clock edge. The state is held until the next start.
- R5: Bytes are sent MSB first. Each bit is valid on `cfg_data` when `cfg_clk` rises. Exactly `byte_len` bytes (captured at start) are sent. `src_ready` is high only while waiting for a byte, after the init poll succeeded, with `prog_n`=1 and `cfg_clk`=0. A byte transfers on a clock edge with `src_valid` and `src_ready` both high.
- R6: With divider value D (0 is treated as 1), each high phase of `cfg_clk` lasts exactly max(D,1) system cycles. `cfg_data` is set before the low phase and is stable through the whole high phase.
- R7: If `src_err` is high while the block waits for a byte, it stops with `fail`=1 and `act_ind`=1, sends nothing further, and issues no more clock edges.
- R8: After the last byte, free clock pulses (low phase, then high phase) are issued for as long as `cfg_done` is seen low at the end of a low phase. If `cfg_done` is already high when the last byte ends, no extra pulse is issued.
- R9: If `cfg_done` is still low after FLUSH_MAX free pulses, the block stops with `fail`=1 and `act_ind`=1.
- R10: On success, `busy`=0, `act_ind`=0 and `success`=1. `success` and `fail` are never both high, and either one holds until the next start.
- R11: A start pulse that arrives while `busy`=1 is ignored. The running sequence continues without a second program pulse and without losing or repeating bytes.
- R12: With `byte_len`=0, the block goes straight from the init poll to the free-clock phase and sends no data bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle request to begin a configuration |
| byte_len | input | LEN_W | Number of image bytes, captured at start |
| div_ratio | input | DIV_W | System cycles per configuration clock phase (0 acts as 1) |
| src_valid | input | 1 | Byte source has a byte |
| src_data | input | 8 | Byte from the source |
| src_err | input | 1 | Byte source reports an unrecoverable error |
| src_ready | output | 1 | Sequencer accepts a byte this cycle |
| init_ready | input | 1 | Target ready-for-data indication |
| cfg_done | input | 1 | Target configuration-complete indication |
| pwr_en | output | 1 | Target supply enable |
| prog_n | output | 1 | Active-low program request to the target |
| cfg_clk | output | 1 | Configuration clock |
| cfg_data | output | 1 | Configuration data bit |
| busy | output | 1 | Sequence in progress |
| act_ind | output | 1 | Activity indicator, cleared only on success |
| success | output | 1 | Last sequence completed |
| fail | output | 1 | Last sequence aborted |

## Verification
The bench aims at the edges of both timeouts. Init-ready arriving on the very last allowed poll must still succeed; a design whose poll limit is off by one would fail it. Init-ready that never arrives must give exactly POLL_MAX polls and no clock edge. A done that never rises must give exactly FLUSH_MAX free pulses; a wrong flush counter shows up as a different pulse count. The bench also covers done already high after the last byte (no extra pulse allowed), a zero-length image, a source error in the middle of the image (a design that ignores it would hang or send stale data), slow divider values (phase width), and a start pulse in the middle of a sequence. A design that restarts on that pulse would show a second program pulse and a broken byte stream.

// File: rtl/cfgseq_pkg.sv
// Package: shared state encoding and byte width for the configuration sequencer.
// Assumes nothing beyond IEEE 1800-2017.
package cfgseq_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [3:0] {
        ST_IDLE,    // waiting for start, nothing reported yet
        ST_POWER,   // supply on, settling
        ST_PROG,    // program line held low
        ST_INIT,    // polling the target's init-ready input
        ST_LOAD,    // waiting for the next byte from the source
        ST_BSET,    // clock low, data bit presented
        ST_BHI,     // clock high, target samples the bit
        ST_FLO,     // free-run clock low, done checked at phase end
        ST_FHI,     // free-run clock high
        ST_OK,      // completed, status held
        ST_FAIL     // aborted, status held
    } seq_state_t;

endpackage

// File: rtl/cfgseq_div.sv
// Module: phase timer for the configuration clock.
// Emits a one-cycle tick every max(div,1) cycles while run is high; the count
// restarts whenever run is low, so the first phase after a pause is full length.
// Assumes div is stable while run is high.
module cfgseq_div #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);

    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] last_val;

    // Terminal count: one below the effective divider value.
    always_comb begin
        last_val = (div == '0) ? '0 : div - 1'b1;
        tick     = run && (cnt == last_val);
    end

    // Phase counter, cleared on pause and at each tick.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || tick) cnt <= '0;
        else                        cnt <= cnt + 1'b1;
    end

endmodule

// File: rtl/cfgseq_shreg.sv
// Module: byte shift register feeding the serial data pin, MSB first.
// load captures a new byte and resets the bit index; shift moves to the next
// bit. last is high while the final bit of the byte is presented.
// Assumes load and shift are never requested in the same cycle.
module cfgseq_shreg #(
    parameter int W = cfgseq_pkg::BYTE_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         shift,
    input  logic [W-1:0] din,
    output logic         msb,
    output logic         last
);

    localparam int IDX_W = $clog2(W);

    logic [W-1:0]     sr;
    logic [IDX_W-1:0] idx;

    // Byte register and bit index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr  <= '0;
            idx <= '0;
        end else if (load) begin
            sr  <= din;
            idx <= '0;
        end else if (shift) begin
            sr  <= {sr[W-2:0], 1'b0};
            idx <= idx + 1'b1;
        end
    end

    // Present the current bit and flag the final one.
    always_comb begin
        msb  = sr[W-1];
        last = (idx == IDX_W'(W - 1));
    end

    // R5: a new byte is never captured in the middle of a shift step.
    assert_load_shift_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(load && shift));

endmodule

// File: rtl/cfgseq_top.sv
// Module: slave-serial configuration sequencer (top).
// Runs supply settle, program pulse, bounded init poll, MSB-first byte shifting
// and bounded free-run clocking until done. Status is held until the next start.
// Assumes init_ready and cfg_done are already synchronous to clk, and that
// div_ratio does not change during a sequence.
module cfgseq_top #(
    parameter int LEN_W     = 24,
    parameter int DIV_W     = 8,
    parameter int PWR_CYC   = 1000,
    parameter int PROG_CYC  = 1000,
    parameter int POLL_MAX  = 100000,
    parameter int FLUSH_MAX = 100000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [LEN_W-1:0] byte_len,
    input  logic [DIV_W-1:0] div_ratio,
    input  logic             src_valid,
    input  logic [7:0]       src_data,
    input  logic             src_err,
    output logic             src_ready,
    input  logic             init_ready,
    input  logic             cfg_done,
    output logic             pwr_en,
    output logic             prog_n,
    output logic             cfg_clk,
    output logic             cfg_data,
    output logic             busy,
    output logic             act_ind,
    output logic             success,
    output logic             fail
);
    import cfgseq_pkg::*;

    localparam int M_A    = (PWR_CYC  > PROG_CYC)  ? PWR_CYC  : PROG_CYC;
    localparam int M_B    = (POLL_MAX > FLUSH_MAX) ? POLL_MAX : FLUSH_MAX;
    localparam int M_ALL  = (M_A > M_B) ? M_A : M_B;
    localparam int WAIT_W = $clog2(M_ALL + 1) + 1;

    seq_state_t       state;
    logic [WAIT_W-1:0] wcnt;
    logic [LEN_W-1:0]  bytes_left;
    logic              ph_run;
    logic              ph_tick;
    logic              sh_load;
    logic              sh_shift;
    logic              sh_msb;
    logic              sh_last;
    logic              pwr_q;
    logic              start_ok;

    cfgseq_div #(.DIV_W(DIV_W)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (ph_run),
        .div   (div_ratio),
        .tick  (ph_tick)
    );

    cfgseq_shreg #(.W(BYTE_W)) u_sh (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (sh_load),
        .shift (sh_shift),
        .din   (src_data),
        .msb   (sh_msb),
        .last  (sh_last)
    );

    // Decode pin levels and handshake strobes from the current state.
    always_comb begin
        busy      = !(state == ST_IDLE || state == ST_OK || state == ST_FAIL);
        start_ok  = start && !busy;
        ph_run    = (state == ST_BSET) || (state == ST_BHI) ||
                    (state == ST_FLO)  || (state == ST_FHI);
        src_ready = (state == ST_LOAD);
        sh_load   = src_ready && src_valid && !src_err;
        sh_shift  = (state == ST_BHI) && ph_tick && !sh_last;
        prog_n    = (state != ST_PROG);
        cfg_clk   = (state == ST_BHI) || (state == ST_FHI);
        cfg_data  = ((state == ST_BSET) || (state == ST_BHI)) ? sh_msb : 1'b0;
        pwr_en    = pwr_q;
        act_ind   = busy || (state == ST_FAIL);
        success   = (state == ST_OK);
        fail      = (state == ST_FAIL);
    end

    // Supply enable: set by an accepted start, kept for the rest of the run.
    always_ff @(posedge clk) begin
        if (!rst_n)        pwr_q <= 1'b0;
        else if (start_ok) pwr_q <= 1'b1;
    end

    // Sequence state, shared wait counter and remaining byte count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            wcnt       <= '0;
            bytes_left <= '0;
        end else begin
            case (state)
                ST_IDLE, ST_OK, ST_FAIL: begin
                    if (start_ok) begin
                        state      <= ST_POWER;
                        wcnt       <= '0;
                        bytes_left <= byte_len;
                    end
                end
                ST_POWER: begin
                    if (wcnt == WAIT_W'(PWR_CYC - 1)) begin
                        state <= ST_PROG;
                        wcnt  <= '0;
                    end else begin
                        wcnt <= wcnt + 1'b1;
                    end
                end
                ST_PROG: begin
                    if (wcnt == WAIT_W'(PROG_CYC - 1)) begin
                        state <= ST_INIT;
                        wcnt  <= '0;
                    end else begin
                        wcnt <= wcnt + 1'b1;
                    end
                end
                ST_INIT: begin
                    if (init_ready) begin
                        state <= (bytes_left == '0) ? ST_FLO : ST_LOAD;
                        wcnt  <= '0;
                    end else if (wcnt == WAIT_W'(POLL_MAX - 1)) begin
                        state <= ST_FAIL;
                    end else begin
                        wcnt <= wcnt + 1'b1;
                    end
                end
                ST_LOAD: begin
                    if (src_err)        state <= ST_FAIL;
                    else if (src_valid) state <= ST_BSET;
                end
                ST_BSET: begin
                    if (ph_tick) state <= ST_BHI;
                end
                ST_BHI: begin
                    if (ph_tick) begin
                        if (!sh_last) begin
                            state <= ST_BSET;
                        end else begin
                            bytes_left <= bytes_left - 1'b1;
                            wcnt       <= '0;
                            state      <= (bytes_left == LEN_W'(1)) ? ST_FLO : ST_LOAD;
                        end
                    end
                end
                ST_FLO: begin
                    if (cfg_done) begin
                        state <= ST_OK;
                    end else if (ph_tick) begin
                        state <= (wcnt == WAIT_W'(FLUSH_MAX)) ? ST_FAIL : ST_FHI;
                    end
                end
                ST_FHI: begin
                    if (ph_tick) begin
                        state <= ST_FLO;
                        wcnt  <= wcnt + 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R2: the program line only drops with the supply already on.
    assert_prog_needs_power_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !prog_n |-> pwr_en);

    // R5: bytes are requested only with the program line released and clock low.
    assert_ready_quiet_pins_R5: assert property (@(posedge clk) disable iff (!rst_n)
        src_ready |-> (prog_n && pwr_en && !cfg_clk));

    // R6: data never moves while the configuration clock is high.
    assert_data_stable_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_clk && $past(cfg_clk)) |-> $stable(cfg_data));

    // R10: completion and abort are exclusive and neither overlaps busy.
    assert_status_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(success && fail) && !(busy && (success || fail)));

    // R10: success holds until a new start.
    assert_success_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (success && !start) |=> success);

    // R4: abort status holds until a new start.
    assert_fail_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (fail && !start) |=> (fail && act_ind));

    // R11: a start during shifting does not re-enter the power phase.
    assert_no_restart_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BSET && start) |=> (state != ST_POWER));

endmodule

// File: tb/sim_cfgseq_top.sv
`timescale 1ns/1ps
// Scoreboard bench: the run task queues expected bytes, the negedge monitor
// rebuilds bytes from the serial pins and compares them in order.
module sim_cfgseq_top;

    localparam int LEN_W = 16;
    localparam int DIV_W = 4;
    localparam int PWR   = 5;
    localparam int PROG  = 4;
    localparam int POLL  = 12;
    localparam int FLUSH = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [LEN_W-1:0] byte_len = '0;
    logic [DIV_W-1:0] div_ratio = 4'd1;
    logic src_valid = 1'b0;
    logic [7:0] src_data = 8'h00;
    logic src_err = 1'b0;
    logic src_ready;
    logic init_ready = 1'b0;
    logic cfg_done = 1'b0;
    logic pwr_en, prog_n, cfg_clk, cfg_data, busy, act_ind, success, fail;

    always #2.5 clk = ~clk;

    cfgseq_top #(.LEN_W(LEN_W), .DIV_W(DIV_W), .PWR_CYC(PWR), .PROG_CYC(PROG),
                 .POLL_MAX(POLL), .FLUSH_MAX(FLUSH)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .byte_len(byte_len),
        .div_ratio(div_ratio), .src_valid(src_valid), .src_data(src_data),
        .src_err(src_err), .src_ready(src_ready), .init_ready(init_ready),
        .cfg_done(cfg_done), .pwr_en(pwr_en), .prog_n(prog_n), .cfg_clk(cfg_clk),
        .cfg_data(cfg_data), .busy(busy), .act_ind(act_ind), .success(success),
        .fail(fail));

    int total = 0;
    int bad = 0;

    // Run configuration shared with the monitor.
    logic [7:0] src_mem [16];
    logic [7:0] exp_q [$];
    int cur_len = 0, eff_div = 1, init_d = 0, done_a = 0, err_at = -1;
    bit mon_on = 1'b0;

    // Monitor state.
    int src_idx = 0, rise_cnt = 0, hi_w = 0, pwr_cnt = 0, low_cnt = 0, rel_cnt = 0;
    int wait_cnt = 0, bit_n = 0;
    bit seen_low = 1'b0, acc_pend = 1'b0, prev_clk = 1'b0;
    logic [7:0] sh_byte = 8'h00;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Source, target model and pin monitor, all sampled away from the active edge.
    always @(negedge clk) begin
        if (rst_n && mon_on) begin
            if (acc_pend) src_idx++;
            src_err   = (err_at >= 0) && (src_idx == err_at);
            src_valid = (src_idx < cur_len) && !src_err;
            src_data  = src_mem[src_idx % 16];
            acc_pend  = src_valid && src_ready;

            if (src_ready && !(prog_n && pwr_en && !cfg_clk && seen_low))
                chk(1'b0, "R5 ready outside byte wait", 1, 0);

            if (pwr_en && prog_n && !seen_low && busy) pwr_cnt++;
            if (!prog_n) begin
                low_cnt++;
                seen_low = 1'b1;
            end
            if (seen_low && prog_n) begin
                init_ready = (init_d >= 0) && (rel_cnt >= init_d);
                rel_cnt++;
                if (busy && rise_cnt == 0 && !src_ready) wait_cnt++;
            end else begin
                init_ready = 1'b0;
            end

            if (cfg_clk && !prev_clk) begin
                rise_cnt++;
                if (rise_cnt <= 8 * cur_len) begin
                    sh_byte = {sh_byte[6:0], cfg_data};
                    bit_n++;
                    if (bit_n == 8) begin
                        bit_n = 0;
                        if (exp_q.size() == 0) chk(1'b0, "R5 unexpected byte", sh_byte, -1);
                        else begin
                            logic [7:0] e;
                            e = exp_q.pop_front();
                            chk(sh_byte == e, "R5 byte order/value", sh_byte, e);
                        end
                    end
                end
            end
            if (cfg_clk) hi_w++;
            if (!cfg_clk && prev_clk) begin
                chk(hi_w == eff_div, "R6 high phase width", hi_w, eff_div);
                hi_w = 0;
            end
            prev_clk = cfg_clk;
            cfg_done = (done_a >= 0) && (rise_cnt >= 8 * cur_len + done_a);
        end
    end

    // One configuration run; restart_at > 0 pulses start again that many cycles in.
    task automatic run_cfg(input int len, input int dv, input int id, input int da,
                           input int ea, input int restart_at);
        int lim;
        @(posedge clk); #1;
        cur_len = len; eff_div = (dv == 0) ? 1 : dv; init_d = id; done_a = da; err_at = ea;
        for (int i = 0; i < len; i++) begin
            src_mem[i] = 8'(8'h5B * (i + 1) + len * 8'h11 + dv);
            if (ea < 0 || i < ea) exp_q.push_back(src_mem[i]);
        end
        src_idx = 0; rise_cnt = 0; hi_w = 0; pwr_cnt = 0; low_cnt = 0; rel_cnt = 0;
        wait_cnt = 0; bit_n = 0; seen_low = 0; acc_pend = 0; prev_clk = 0;
        byte_len = LEN_W'(len); div_ratio = DIV_W'(dv);
        mon_on = 1'b1;
        start = 1'b1;
        @(posedge clk); #1;
        start = 1'b0;
        lim = 0;
        while (busy && lim < 5000) begin
            @(posedge clk); #1;
            lim++;
            if (restart_at > 0 && lim == restart_at) start = 1'b1;
            else start = 1'b0;
        end
        start = 1'b0;
        chk(lim < 5000, "watchdog run end", lim, 5000);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1: idle pins after reset.
        chk(prog_n && !cfg_clk && !cfg_data && !pwr_en && !src_ready && !busy &&
            !act_ind && !success && !fail, "R1 reset state",
            {prog_n, cfg_clk, cfg_data, pwr_en, src_ready, busy, act_ind, success, fail},
            9'b100000000);

        // Nominal run, divider 1, done after two free pulses.
        run_cfg(3, 1, 3, 2, -1, 0);
        chk(pwr_cnt == PWR, "R2 settle length", pwr_cnt, PWR);
        chk(low_cnt == PROG, "R3 program pulse length", low_cnt, PROG);
        chk(exp_q.size() == 0, "R5 all bytes sent", exp_q.size(), 0);
        chk(rise_cnt - 24 == 2, "R8 free pulses until done", rise_cnt - 24, 2);
        chk(success && !fail && !act_ind && !busy, "R10 success status",
            {success, fail, act_ind, busy}, 4'b1000);
        repeat (5) @(negedge clk);
        chk(success, "R10 status held", success, 1);

        // Slow divider, done already high after the last byte.
        run_cfg(2, 3, 0, 0, -1, 0);
        chk(exp_q.size() == 0, "R6 bytes with divider 3", exp_q.size(), 0);
        chk(rise_cnt == 16, "R8 no extra pulse when done high", rise_cnt, 16);
        chk(success, "R8 completes", success, 1);

        // Divider 0 behaves as 1.
        run_cfg(1, 0, 1, 1, -1, 0);
        chk(success && exp_q.size() == 0, "R6 divider zero", success, 1);

        // Zero-length image.
        run_cfg(0, 2, 2, 3, -1, 0);
        chk(rise_cnt == 3, "R12 only free pulses", rise_cnt, 3);
        chk(success, "R12 success", success, 1);

        // Init never comes.
        run_cfg(2, 1, -1, 0, -1, 0);
        chk(wait_cnt == POLL, "R4 poll count", wait_cnt, POLL);
        chk(fail && act_ind && !busy && !success, "R4 abort flags",
            {fail, act_ind, busy, success}, 4'b1100);
        chk(rise_cnt == 0, "R4 no clock edge", rise_cnt, 0);
        exp_q.delete();
        repeat (5) @(negedge clk);
        chk(fail && act_ind, "R4 status held", fail, 1);

        // Init on the very last allowed poll.
        run_cfg(1, 1, POLL - 1, 1, -1, 0);
        chk(success && exp_q.size() == 0, "R4 last poll accepted", success, 1);

        // Done never rises.
        run_cfg(1, 2, 0, -1, -1, 0);
        chk(rise_cnt - 8 == FLUSH, "R9 free pulse limit", rise_cnt - 8, FLUSH);
        chk(fail && act_ind && !success, "R9 abort flags", fail, 1);

        // Source error after two of four bytes.
        run_cfg(4, 1, 1, 0, 2, 0);
        chk(rise_cnt == 16, "R7 stops at error", rise_cnt, 16);
        chk(fail && act_ind && exp_q.size() == 0, "R7 abort flags", fail, 1);

        // Start pulse during shifting is ignored.
        run_cfg(3, 2, 1, 1, -1, 30);
        chk(low_cnt == PROG, "R11 single program pulse", low_cnt, PROG);
        chk(exp_q.size() == 0 && success, "R11 stream intact", exp_q.size(), 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Global watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule